// File: doc/BRIEF.md
# Planar Memory Read Path

This block forms the byte handed back to the processor when it reads a frame buffer that is split into four 8-bit bit planes. It has two read modes. In direct mode it returns the byte of one chosen plane. In compare mode it returns eight match flags, one for each pixel position of the byte. Each flag tells whether the 4-bit pixel made up of that bit from all planes equals a reference colour. Planes marked as "don't care" are left out of that comparison.

Plane choice can be steered by the low address bit for odd/even addressing. When steering is on, the upper bit of the plane select picks a pair of planes (0/1 or 2/3), and address bit 0 picks the plane within that pair. The odd/even setting arrives on two control inputs of opposite polarity, which must always agree. The result is available combinationally and is also captured into a register on each read strobe.

Top module: `pr_read_path`

## Requirements
- R1: While reset is asserted and after its release, the registered read output `rd_data` is 8'h00 until the first read strobe.
- R2: In direct mode (`read_mode`=0) with steering off, `rd_comb` equals plane `map_sel`, where plane k occupies `plane_data[8k+7:8k]`.
- R3: In direct mode with steering on (`oe_enable`=1), the plane read is index {`map_sel[1]`, `addr_lsb`}, and `map_sel[0]` has no effect.
- R4: In direct mode with steering off, `addr_lsb` has no effect on `rd_comb`.
- R5: In compare mode (`read_mode`=1) with all planes cared for (`cmp_care`=4'hF), bit b of `rd_comb` is 1 exactly when bit b of plane k equals `cmp_color[k]` for every k.
- R6: In compare mode, a plane whose `cmp_care` bit is 0 is left out of the comparison. With `cmp_care`=4'h0, `rd_comb` is 8'hFF.
- R7: When `rd_strobe` is high at a rising clock edge, `rd_data` takes the value `rd_comb` had at that edge. Otherwise `rd_data` holds its value.
- R8: In compare mode, `map_sel`, `addr_lsb` and the odd/even controls have no effect on `rd_comb`.
- R9: `oe_alt_n` is always the inverse of `oe_enable`. Steering follows `oe_enable`=1 / `oe_alt_n`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| plane_data | input | 32 | Four plane bytes, plane k at bits 8k+7:8k |
| addr_lsb | input | 1 | CPU address bit 0 |
| read_mode | input | 1 | 0 direct, 1 colour compare |
| oe_enable | input | 1 | Odd/even steering on when 1 |
| oe_alt_n | input | 1 | Same control, opposite polarity |
| map_sel | input | 2 | Plane select for direct reads |
| cmp_color | input | 4 | Reference colour, bit k for plane k |
| cmp_care | input | 4 | Per-plane compare enable |
| rd_strobe | input | 1 | Captures the read result |
| rd_comb | output | 8 | Combinational read result |
| rd_data | output | 8 | Registered read result |

## Verification
The hardest case to reach is a compare result in which some pixel positions match only because a mismatching plane is masked out. Uniform plane data cannot tell a dropped care bit apart from a correct one. The stimulus therefore uses plane bytes that differ bit by bit, together with colours chosen to fail in exactly one plane. Each care mask is then swept so that every plane in turn is the only cause of a mismatch.

// File: rtl/pr_pkg.sv
package pr_pkg;
    parameter int PLANES = 4;
    parameter int PIX_W  = 8;
    localparam int SEL_W = $clog2(PLANES);
endpackage

// File: rtl/pr_plane_sel.sv
module pr_plane_sel
    import pr_pkg::*;
(
    input  logic [PLANES*PIX_W-1:0] planes,
    input  logic [SEL_W-1:0]        map_sel,
    input  logic                    addr_lsb,
    input  logic                    steer,
    output logic [PIX_W-1:0]        byte_out
);
    logic [PIX_W-1:0] plane_arr [PLANES];
    logic [SEL_W-1:0] idx;

    for (genvar k = 0; k < PLANES; k++) begin : g_unpack
        assign plane_arr[k] = planes[k*PIX_W +: PIX_W];
    end

    always_comb begin
        if (steer) idx = {map_sel[SEL_W-1:1], addr_lsb};
        else       idx = map_sel;
        byte_out = plane_arr[idx];
    end
endmodule

// File: rtl/pr_color_cmp.sv
module pr_color_cmp
    import pr_pkg::*;
(
    input  logic [PLANES*PIX_W-1:0] planes,
    input  logic [PLANES-1:0]       color,
    input  logic [PLANES-1:0]       care,
    output logic [PIX_W-1:0]        match
);
    for (genvar b = 0; b < PIX_W; b++) begin : g_pix
        logic [PLANES-1:0] miss;
        for (genvar k = 0; k < PLANES; k++) begin : g_pl
            assign miss[k] = (planes[k*PIX_W + b] ^ color[k]) & care[k];
        end
        assign match[b] = ~|miss;
    end
endmodule

// File: rtl/pr_read_path.sv
module pr_read_path
    import pr_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [PLANES*PIX_W-1:0] plane_data,
    input  logic                    addr_lsb,
    input  logic                    read_mode,
    input  logic                    oe_enable,
    input  logic                    oe_alt_n,
    input  logic [SEL_W-1:0]        map_sel,
    input  logic [PLANES-1:0]       cmp_color,
    input  logic [PLANES-1:0]       cmp_care,
    input  logic                    rd_strobe,
    output logic [PIX_W-1:0]        rd_comb,
    output logic [PIX_W-1:0]        rd_data
);
    logic [PIX_W-1:0] direct_byte;
    logic [PIX_W-1:0] match_byte;

    pr_plane_sel i_sel (
        .planes   (plane_data),
        .map_sel  (map_sel),
        .addr_lsb (addr_lsb),
        .steer    (oe_enable),
        .byte_out (direct_byte)
    );

    pr_color_cmp i_cmp (
        .planes (plane_data),
        .color  (cmp_color),
        .care   (cmp_care),
        .match  (match_byte)
    );

    always_comb begin
        rd_comb = read_mode ? match_byte : direct_byte;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)         rd_data <= '0;
        else if (rd_strobe) rd_data <= rd_comb;
    end

    AST_OE_CONSISTENT: assert property (@(posedge clk) disable iff (!rst_n)
        oe_enable != oe_alt_n); // R9
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_strobe |=> $stable(rd_data)); // R7
    AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe |=> rd_data == $past(rd_comb)); // R7
    AST_CARE_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        (read_mode && cmp_care == '0) |-> rd_comb == '1); // R6
    AST_PAIR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!read_mode && oe_enable && !map_sel[SEL_W-1]) |->
        (rd_comb == plane_data[0 +: PIX_W] || rd_comb == plane_data[PIX_W +: PIX_W])); // R3
endmodule

// File: tb/test_pr_read_path.sv
module test_pr_read_path;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [31:0] plane_data = '0;
    logic        addr_lsb = 0, read_mode = 0, oe_enable = 0, oe_alt_n = 1;
    logic [1:0]  map_sel = 0;
    logic [3:0]  cmp_color = 0, cmp_care = 4'hF;
    logic        rd_strobe = 0;
    logic [7:0]  rd_comb, rd_data;
    int total = 0, bad = 0;

    always #10 clk = ~clk;

    pr_read_path i_pr_read_path (.*);

    function automatic logic [7:0] plane_of(logic [31:0] p, int k);
        return p[k*8 +: 8];
    endfunction

    function automatic logic [7:0] exp_cmp(logic [31:0] p, logic [3:0] c, logic [3:0] m);
        logic [7:0] r;
        for (int b = 0; b < 8; b++) begin
            r[b] = 1'b1;
            for (int k = 0; k < 4; k++)
                if (m[k] && (p[k*8+b] != c[k])) r[b] = 1'b0;
        end
        return r;
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_oe(logic on);
        oe_enable = on; oe_alt_n = ~on;
    endtask

    task automatic t_reset();
        @(negedge clk); chk("R1", rd_data, 8'h00);
        rst_n = 1;
        @(negedge clk); chk("R1", rd_data, 8'h00);
    endtask

    task automatic t_direct();
        plane_data = 32'hA5_3C_0F_71; read_mode = 0; set_oe(0);
        for (int s = 0; s < 4; s++) begin
            map_sel = s[1:0];
            addr_lsb = 0; #1 chk("R2", rd_comb, plane_of(plane_data, s));
            addr_lsb = 1; #1 chk("R4", rd_comb, plane_of(plane_data, s));
        end
    endtask

    task automatic t_oddeven();
        plane_data = 32'hD2_47_9E_18; read_mode = 0; set_oe(1);
        for (int s = 0; s < 4; s++) begin
            for (int a = 0; a < 2; a++) begin
                map_sel = s[1:0]; addr_lsb = a[0];
                #1 chk("R3 R9", rd_comb, plane_of(plane_data, (s & 2) | a));
            end
        end
        set_oe(0);
    endtask

    task automatic t_compare_all();
        read_mode = 1; cmp_care = 4'hF;
        plane_data = 32'hF0_CC_AA_FF; cmp_color = 4'b0101;
        #1 chk("R5", rd_comb, exp_cmp(plane_data, cmp_color, 4'hF));
        plane_data = 32'hFF_FF_FF_FF; cmp_color = 4'hF;
        #1 chk("R5", rd_comb, 8'hFF);
        cmp_color = 4'hE;
        #1 chk("R5", rd_comb, 8'h00);
        for (int i = 0; i < 6; i++) begin
            plane_data = $urandom; cmp_color = 4'($urandom);
            #1 chk("R5", rd_comb, exp_cmp(plane_data, cmp_color, 4'hF));
        end
    endtask

    task automatic t_care();
        read_mode = 1;
        plane_data = 32'h00_00_00_00; cmp_color = 4'h0;
        for (int k = 0; k < 4; k++) begin
            plane_data = 32'hFF << (k*8);
            cmp_care = 4'hF; #1 chk("R6", rd_comb, 8'h00);
            cmp_care = 4'hF & ~(4'b1 << k); #1 chk("R6", rd_comb, 8'hFF);
        end
        plane_data = 32'h5A_C3_96_0F; cmp_color = 4'b1010;
        for (int m = 0; m < 16; m++) begin
            cmp_care = m[3:0];
            #1 chk("R6", rd_comb, exp_cmp(plane_data, cmp_color, m[3:0]));
        end
        cmp_care = 4'h0; plane_data = $urandom;
        #1 chk("R6", rd_comb, 8'hFF);
        cmp_care = 4'hF;
    endtask

    task automatic t_cmp_ignore();
        logic [7:0] ref_v;
        read_mode = 1; plane_data = 32'h39_E4_72_1B; cmp_color = 4'b0110; cmp_care = 4'hF;
        ref_v = exp_cmp(plane_data, cmp_color, 4'hF);
        for (int s = 0; s < 4; s++) begin
            map_sel = s[1:0]; addr_lsb = s[0]; set_oe(s[1]);
            #1 chk("R8", rd_comb, ref_v);
        end
        set_oe(0);
    endtask

    task automatic t_register();
        logic [7:0] held;
        read_mode = 0; set_oe(0); map_sel = 2; plane_data = 32'h11_C7_22_33;
        @(negedge clk); rd_strobe = 1;
        @(negedge clk); rd_strobe = 0;
        chk("R7", rd_data, 8'hC7);
        held = rd_data;
        plane_data = 32'h44_55_66_77;
        @(negedge clk); @(negedge clk);
        chk("R7", rd_data, held);
        read_mode = 1; cmp_care = 4'h0; rd_strobe = 1;
        @(negedge clk); rd_strobe = 0;
        chk("R7", rd_data, 8'hFF);
        read_mode = 0; map_sel = 0; rd_strobe = 1;
        @(negedge clk); rd_strobe = 0;
        chk("R7", rd_data, 8'h77);
        cmp_care = 4'hF;
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_direct();
                t_oddeven();
                t_compare_all();
                t_care();
                t_cmp_ignore();
                t_register();
            end
            begin
                repeat (20000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule